// File: doc/BRIEF.md
# Fractional Programmable Clock Divider

This block turns a free-running clock into a stream of single-cycle enable pulses whose average rate is the input rate divided by a programmable divisor. The divisor may have a fractional part. It is taken from a bit field of a 32-bit divider word. The field sits at a parameterised offset and has a parameterised width. Its lowest bits hold the fraction in fixed point. The bits above them hold the integer part of the divisor, stored as the divisor minus one.

Internally, all arithmetic works on divisors scaled by two to the power of the fraction width, so no precision is lost. On every advancing cycle, a phase accumulator gains one scaled unit. When the accumulator would reach the divisor, the divisor is taken away and a pulse is issued.

An optional fixed pre-divider can sit ahead of the accumulator. It lets the accumulator advance only once in every fixed number of input cycles. A new divisor is captured when a commit strobe is seen. It is put into use only at a pulse boundary, so no output period is ever built from two different divisors.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is held, `tick_o` is low. After reset the active divisor is 1.0.
- R2: The divisor field is bits `[FIELD_SHIFT +: FIELD_W]` of `div_word_i`. Bits outside that range have no effect on the pulse stream.
- R3: The field's integer bits (above the lowest `FRAC_W` bits) hold the integer divisor minus one. With a zero fraction, an integer divisor N gives exactly one pulse every N advancing cycles.
- R4: The lowest `FRAC_W` bits of the field are the fraction. Over time, a divisor D = (field + 2^FRAC_W) / 2^FRAC_W gives a pulse each time the advance count, times 2^FRAC_W, crosses another multiple of the scaled divisor. That is an average of one pulse per D advancing cycles, with an error of no more than one cycle on any period.
- R5: A divisor of exactly 1.0 (field zero) gives a pulse on every advancing cycle.
- R6: A change of `div_word_i` while `commit_i` is low has no effect.
- R7: A divisor committed on a cycle with no pulse waits. It takes effect at the next pulse. The pulse that ends the current period is still timed with the old divisor. A later commit before that pulse replaces the waiting value.
- R8: A commit on the same cycle as a pulse is put into use at that pulse boundary. It governs the very next period.
- R9: With `PRE_DIV` greater than one, the accumulator advances only once every `PRE_DIV` input cycles. Pulses occur only on those cycles, so each pulse is one cycle wide and two pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_word_i | input | 32 | Divider word carrying the divisor field |
| commit_i | input | 1 | Strobe that captures the divisor field |
| tick_o | output | 1 | Divided enable pulse, one cycle wide |

## Verification
The boundary that matters is where a commit strobe falls on the same cycle as a pulse. The block must then put the new divisor straight into use, rather than holding it as a waiting value for one more period. The bench provokes this by looking ahead in its own model: it asserts the strobe exactly on the edge that the model says will carry a pulse. It also commits on cycles between pulses, and commits twice while a value is waiting. A behavioural accumulator in integers is compared with the output on every clock, so a period that is stretched or cut short shows up as a mismatch.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
   localparam int unsigned DIV_WORD_W = 32;
   typedef logic [DIV_WORD_W-1:0] div_word_t;
endpackage

// File: rtl/frac_div_field.sv
module frac_div_field
   import frac_div_pkg::*;
#(
   parameter int unsigned FIELD_SHIFT = 8,
   parameter int unsigned FIELD_W     = 8,
   parameter int unsigned FRAC_W      = 3,
   localparam int unsigned DW         = FIELD_W + 1
) (
   input  div_word_t        div_word_i,
   output logic [DW-1:0]    scaled_o
);
   localparam logic [DW-1:0] ONE = DW'(1) << FRAC_W;

   // configuration checks at elaboration
   if (FRAC_W >= FIELD_W) begin : g_bad_frac
      $error("fraction width must be below field width");
   end
   if (FIELD_SHIFT + FIELD_W > DIV_WORD_W) begin : g_bad_pos
      $error("field does not fit in the divider word");
   end

   logic [FIELD_W-1:0] field;
   logic               unused_word_bits;

   assign field            = div_word_i[FIELD_SHIFT +: FIELD_W];
   assign unused_word_bits = ^div_word_i;
   // stored value is divisor minus one above the fraction: add one scaled unit
   assign scaled_o         = {1'b0, field} + ONE;
endmodule

// File: rtl/frac_div_prediv.sv
module frac_div_prediv #(
   parameter int unsigned PRE_DIV = 1,
   localparam int unsigned CW     = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic adv_o
);
   if (PRE_DIV == 0) begin : g_bad_pre
      $error("pre-divider must be non-zero");
   end

   if (PRE_DIV <= 1) begin : g_bypass
      assign adv_o = 1'b1;
   end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            cnt_q <= '0;
         end else if (cnt_q == LAST) begin
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign adv_o = (cnt_q == LAST);

      // R9
      adv_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         adv_o |=> !adv_o);
   end
endmodule

// File: rtl/frac_div_accum.sv
module frac_div_accum #(
   parameter int unsigned FIELD_W = 8,
   parameter int unsigned FRAC_W  = 3,
   localparam int unsigned DW     = FIELD_W + 1
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          adv_i,
   input  logic          commit_i,
   input  logic [DW-1:0] new_div_i,
   output logic          tick_o
);
   localparam logic [DW-1:0] ONE = DW'(1) << FRAC_W;

   logic [DW-1:0] acc_q;
   logic [DW-1:0] div_q;
   logic [DW-1:0] pend_q;
   logic          pend_v_q;
   logic          hit;
   logic [DW-1:0] acc_inc;

   assign acc_inc = acc_q + ONE;
   // acc + ONE >= div  <=>  acc >= div - ONE (div is never below ONE)
   assign hit     = adv_i && (acc_q >= (div_q - ONE));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         acc_q    <= '0;
         div_q    <= ONE;
         pend_q   <= ONE;
         pend_v_q <= 1'b0;
         tick_o   <= 1'b0;
      end else begin
         tick_o <= hit;
         if (hit) begin
            acc_q    <= acc_inc - div_q;
            pend_v_q <= 1'b0;
            if (commit_i) begin
               div_q <= new_div_i;
            end else if (pend_v_q) begin
               div_q <= pend_q;
            end
         end else begin
            if (adv_i) begin
               acc_q <= acc_inc;
            end
            if (commit_i) begin
               pend_q   <= new_div_i;
               pend_v_q <= 1'b1;
            end
         end
      end
   end

   // R4
   acc_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      acc_q < div_q);

   // R6
   div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!commit_i && !pend_v_q) |=> $stable(div_q));

   // R7
   pend_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_v_q && !hit) |=> pend_v_q);
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
   import frac_div_pkg::*;
#(
   parameter int unsigned FIELD_SHIFT = 8,
   parameter int unsigned FIELD_W     = 8,
   parameter int unsigned FRAC_W      = 3,
   parameter int unsigned PRE_DIV     = 1
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic [31:0] div_word_i,
   input  logic        commit_i,
   output logic        tick_o
);
   localparam int unsigned DW = FIELD_W + 1;

   logic [DW-1:0] scaled_div;
   logic          adv_en;

   frac_div_field #(
      .FIELD_SHIFT (FIELD_SHIFT),
      .FIELD_W     (FIELD_W),
      .FRAC_W      (FRAC_W)
   ) u_field (
      .div_word_i (div_word_i),
      .scaled_o   (scaled_div)
   );

   frac_div_prediv #(
      .PRE_DIV (PRE_DIV)
   ) u_prediv (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_o  (adv_en)
   );

   frac_div_accum #(
      .FIELD_W (FIELD_W),
      .FRAC_W  (FRAC_W)
   ) u_accum (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .adv_i     (adv_en),
      .commit_i  (commit_i),
      .new_div_i (scaled_div),
      .tick_o    (tick_o)
   );

   // R9
   tick_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_o |-> $past(adv_en));
endmodule

// File: tb/frac_clk_div_tb.sv
module frac_clk_div_tb;
   localparam int SH  = 4;
   localparam int FW  = 6;
   localparam int FR  = 2;
   localparam int PD  = 2;
   localparam int ONE = 1 << FR;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] div_word = '0;
   logic        commit = 1'b0;
   logic        tick;

   int checks = 0;
   int fails  = 0;
   string req = "R1";

   // behavioural model state
   int  m_pc, m_acc, m_act, m_pend;
   bit  m_pv, m_tick;

   always #4 clk = ~clk;

   frac_clk_div #(
      .FIELD_SHIFT (SH),
      .FIELD_W     (FW),
      .FRAC_W      (FR),
      .PRE_DIV     (PD)
   ) u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .div_word_i (div_word),
      .commit_i   (commit),
      .tick_o     (tick)
   );

   function automatic int field_scaled(logic [31:0] w);
      return int'((w >> SH) & ((1 << FW) - 1)) + ONE;
   endfunction

   // word for divisor int_part + frac/ONE
   function automatic logic [31:0] mk(int int_part, int frac);
      return 32'(((((int_part - 1) << FR) | frac)) << SH);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pc = 0; m_acc = 0; m_act = ONE; m_pend = ONE; m_pv = 0; m_tick = 0;
      end else begin
         bit adv;
         adv  = (m_pc == PD - 1);
         m_pc = adv ? 0 : m_pc + 1;
         if (adv && (m_acc + ONE >= m_act)) begin
            m_acc  = m_acc + ONE - m_act;
            m_tick = 1;
            if (commit) m_act = field_scaled(div_word);
            else if (m_pv) m_act = m_pend;
            m_pv = 0;
         end else begin
            if (adv) m_acc = m_acc + ONE;
            m_tick = 0;
            if (commit) begin m_pend = field_scaled(div_word); m_pv = 1; end
         end
      end
   end

   task automatic check(string r, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison
   always @(negedge clk) begin
      if (rst_n) check(req, int'(tick), int'(m_tick));
   end

   function automatic bit next_edge_hits();
      return (m_pc == PD - 1) && (m_acc + ONE >= m_act);
   endfunction

   task automatic run(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic commit_word(logic [31:0] w);
      @(negedge clk);
      div_word = w;
      commit   = 1'b1;
      @(negedge clk);
      commit   = 1'b0;
   endtask

   initial begin
      #1000000;
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      run(3);
      check("R1", int'(tick), 0);           // R1 reset holds tick low
      rst_n = 1'b1;

      req = "R5";                            // R5 default 1.0, every advance
      run(4);
      begin
         int cnt = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cnt += int'(tick);
         end
         check("R9", cnt, 20 / PD);          // R9 one pulse per pre-divided step
      end

      req = "R3";                            // R3 integer divisor 4
      commit_word(mk(4, 0));
      run(40);
      req = "R3";
      commit_word(mk(7, 0));
      run(60);

      req = "R4";                            // R4 fractional divisors
      commit_word(mk(2, 2));
      run(60);
      commit_word(mk(3, 1));
      run(60);
      commit_word(32'((((1 << FW) - 1)) << SH));
      run(200);

      req = "R2";                            // R2 bits outside the field ignored
      commit_word(mk(3, 1) | 32'hFFFF_FC0F);
      run(60);

      req = "R6";                            // R6 word change without commit
      @(negedge clk);
      div_word = mk(9, 3);
      run(60);
      div_word = 32'hFFFF_FFFF;
      run(40);

      req = "R7";                            // R7 commit waits for pulse
      commit_word(mk(8, 0));
      run(5);
      commit_word(mk(5, 2));
      run(3);
      commit_word(mk(2, 0));
      run(80);

      req = "R8";                            // R8 commit coinciding with pulse
      commit_word(mk(3, 0));
      run(20);
      for (int k = 0; k < 4; k++) begin
         int guard = 0;
         while (!next_edge_hits() && guard < 100) begin
            @(negedge clk);
            guard++;
         end
         div_word = (k % 2 == 0) ? mk(1, 2) : mk(4, 3);
         commit   = 1'b1;
         @(negedge clk);
         commit   = 1'b0;
         run(30);
      end

      req = "R5";
      commit_word(mk(1, 0));
      run(30);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule